// File: doc/BRIEF.md
# Fractional Lane Clock Divider

This block turns the system clock into per-lane clock-enable pulses. Each lane owns a fixed-point divisor made of a 16-bit integer part and an 8-bit fraction. It emits a one-cycle enable at an average rate of the system clock frequency divided by that divisor. The fraction is spread over time by an 8-bit phase accumulator. Each period therefore lasts either the integer value or one cycle more, and the long-run average is exact.

Lanes are written through a small register port that selects one lane per write. Enable and restart are separate per-lane bit vectors. Restart bits asserted in the same cycle clear the phase of several lanes at once, so those lanes tick together afterwards. The output is only a qualifier for logic that runs on the system clock; no clock net is generated.

Top module: `frdiv_lanes`

## Requirements
- R1: After reset every lane holds divisor 1.0 with a cleared phase. A disabled lane shows no tick, and an enabled lane with no write ticks in every cycle.
- R2: When cfg_we is high, the lane selected by cfg_lane takes integer part cfg_wdata[31:16] and fraction cfg_wdata[15:8] at the clock edge. Other lanes keep their divisors.
- R3: With fraction 0 and integer part N (N >= 1), consecutive ticks are exactly N enabled cycles apart.
- R4: An integer part of 0 acts as 65536, so ticks are 65536 enabled cycles apart when the fraction is 0.
- R5: Counting enabled cycles e from the first tick after a restart, tick k falls at e = k*I + floor(k*F/256), where I is the effective integer part and F the fraction. Each gap is therefore I or I+1, and 256 periods span exactly 256*I + F cycles.
- R6: Divisor 1.0 gives a tick in every enabled cycle.
- R7: A restart clears the period counter and the fraction accumulator. In the cycle after the restart an enabled lane ticks. Lanes restarted in the same cycle stay aligned.
- R8: While lane_en is low for a lane, its tick is low and its counter and accumulator hold. On re-enable the sequence continues as if the disabled cycles had not happened.
- R9: A divisor written in the middle of a period does not shorten or stretch that period. It takes effect from the period that starts at the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| cfg_we | input | 1 | Divisor write strobe |
| cfg_lane | input | LANE_W | Lane selected by the write |
| cfg_wdata | input | 24 (bits 31:8) | Divisor word: integer in [31:16], fraction in [15:8] |
| lane_en | input | NLANES | Per-lane run enable |
| lane_restart | input | NLANES | Per-lane phase restart |
| lane_tick | output | NLANES | Per-lane single-cycle enable pulse |

## Verification
The assertions assume that cfg_lane always names an existing lane when cfg_we is high. They also assume that enable and restart change only between clock edges, so that a restart is followed by a clean count from zero. The gap bound assumes that the longest possible period is 65537 cycles (integer field 0 with a non-zero fraction). The stimulus writes only lanes that exist and changes every input on the falling edge. It runs each divisor from a restart, so every expected tick position follows from the closed-form formula in R5.

// File: rtl/frdiv_pkg.sv
package frdiv_pkg;

  localparam int INT_W     = 16;
  localparam int FRAC_W    = 8;
  localparam int CNT_W     = INT_W + 1;
  localparam int FIELD_LSB = 8;
  localparam int WORD_MSB  = FIELD_LSB + FRAC_W + INT_W - 1;

  typedef struct packed {
    logic [INT_W-1:0]  ipart;
    logic [FRAC_W-1:0] fpart;
  } frdiv_div_t;

  localparam frdiv_div_t DIV_RESET = '{ipart: INT_W'(1), fpart: '0};

  // Effective integer span: a zero field stands for 2**INT_W.
  function automatic logic [CNT_W-1:0] int_span(input logic [INT_W-1:0] ip);
    logic [CNT_W-1:0] r;
    if (ip == '0) begin
      r = '0;
      r[INT_W] = 1'b1;
    end else begin
      r = {1'b0, ip};
    end
    return r;
  endfunction

endpackage

// File: rtl/frdiv_divreg.sv
module frdiv_divreg
  import frdiv_pkg::*;
#(
  parameter int NLANES = 4,
  parameter int LANE_W = (NLANES > 1) ? $clog2(NLANES) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [LANE_W-1:0]             cfg_lane,
  input  logic [WORD_MSB:FIELD_LSB]     cfg_wdata,
  output frdiv_div_t [NLANES-1:0]       div_o
);

  frdiv_div_t wr_val;

  always_comb begin
    wr_val.ipart = cfg_wdata[WORD_MSB -: INT_W];
    wr_val.fpart = cfg_wdata[FIELD_LSB +: FRAC_W];
  end

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    frdiv_div_t div_q, div_d;
    logic       hit;

    always_comb begin
      hit   = cfg_we && (cfg_lane == LANE_W'(g));
      div_d = div_q;
      if (hit) begin
        div_d = wr_val;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        div_q <= DIV_RESET;
      end else if (hit) begin
        div_q <= div_d;
      end
    end

    assign div_o[g] = div_q;
  end

endmodule

// File: rtl/frdiv_phase.sv
module frdiv_phase
  import frdiv_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       restart,
  input  frdiv_div_t div,
  output logic       tick
);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [FRAC_W-1:0] acc_q, acc_d;
  logic [FRAC_W:0]   acc_sum;
  logic [CNT_W-1:0]  span;
  logic              at_zero;
  logic              upd;

  always_comb begin
    at_zero = (cnt_q == '0);
    tick    = en && at_zero;
    acc_sum = {1'b0, acc_q} + {1'b0, div.fpart};
    span    = int_span(div.ipart) + CNT_W'(acc_sum[FRAC_W]);
    cnt_d   = cnt_q;
    acc_d   = acc_q;
    upd     = restart || en;
    if (restart) begin
      cnt_d = '0;
      acc_d = '0;
    end else if (en) begin
      if (at_zero) begin
        cnt_d = span - CNT_W'(1);
        acc_d = acc_sum[FRAC_W-1:0];
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else if (upd) begin
      cnt_q <= cnt_d;
      acc_q <= acc_d;
    end
  end

endmodule

// File: rtl/frdiv_lanes.sv
module frdiv_lanes
  import frdiv_pkg::*;
#(
  parameter int NLANES = 4,
  parameter int LANE_W = (NLANES > 1) ? $clog2(NLANES) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [LANE_W-1:0]         cfg_lane,
  input  logic [WORD_MSB:FIELD_LSB] cfg_wdata,
  input  logic [NLANES-1:0]         lane_en,
  input  logic [NLANES-1:0]         lane_restart,
  output logic [NLANES-1:0]         lane_tick
);

  frdiv_div_t [NLANES-1:0] div_w;

  frdiv_divreg #(
    .NLANES (NLANES),
    .LANE_W (LANE_W)
  ) u_divreg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_lane  (cfg_lane),
    .cfg_wdata (cfg_wdata),
    .div_o     (div_w)
  );

  for (genvar g = 0; g < NLANES; g++) begin : g_ph
    frdiv_phase u_phase (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (lane_en[g]),
      .restart (lane_restart[g]),
      .div     (div_w[g]),
      .tick    (lane_tick[g])
    );
  end

endmodule

// File: rtl/frdiv_chk.sv
module frdiv_chk
  import frdiv_pkg::*;
#(
  parameter int NLANES = 4,
  parameter int LANE_W = (NLANES > 1) ? $clog2(NLANES) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [LANE_W-1:0] cfg_lane,
  input logic [NLANES-1:0] lane_en,
  input logic [NLANES-1:0] lane_restart,
  input logic [NLANES-1:0] lane_tick
);

  localparam int GAP_W = CNT_W + 1;
  localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(1) << INT_W;

  p_lane_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> (32'(cfg_lane) < NLANES));

  for (genvar g = 0; g < NLANES; g++) begin : g_c
    logic [GAP_W-1:0] gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        gap_q <= '0;
      end else if (lane_restart[g] || lane_tick[g]) begin
        gap_q <= '0;
      end else if (lane_en[g]) begin
        gap_q <= gap_q + GAP_W'(1);
      end
    end

    p_quiet_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !lane_en[g] |-> !lane_tick[g]);

    p_tick_after_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
      lane_restart[g] |=> (!lane_en[g] || lane_tick[g]));

    p_gap_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      gap_q <= GAP_MAX);
  end

endmodule

bind frdiv_lanes frdiv_chk #(
  .NLANES (NLANES),
  .LANE_W (LANE_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_we       (cfg_we),
  .cfg_lane     (cfg_lane),
  .lane_en      (lane_en),
  .lane_restart (lane_restart),
  .lane_tick    (lane_tick)
);

// File: tb/sim_frdiv_lanes.sv
module sim_frdiv_lanes;

  localparam int NL = 4;

  logic          clk;
  logic          rst_n;
  logic          cfg_we;
  logic [1:0]    cfg_lane;
  logic [31:8]   cfg_wdata;
  logic [NL-1:0] lane_en;
  logic [NL-1:0] lane_restart;
  logic [NL-1:0] lane_tick;

  int compared;
  int mismatched;

  frdiv_lanes #(.NLANES(NL)) u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_lane     (cfg_lane),
    .cfg_wdata    (cfg_wdata),
    .lane_en      (lane_en),
    .lane_restart (lane_restart),
    .lane_tick    (lane_tick)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic bit exp_tick(longint e, longint ip, longint fp);
    longint ie = (ip == 0) ? 65536 : ip;
    longint d  = 256 * ie + fp;
    longint k  = (256 * e + d - 1) / d;
    return (k * ie + (k * fp) / 256) == e;
  endfunction

  task automatic chk(logic got, logic expv, string req, int lane, longint e);
    compared++;
    if (got !== expv) begin
      mismatched++;
      $display("FAIL %s lane %0d e=%0d: got %0b expected %0b", req, lane, e, got, expv);
    end
  endtask

  task automatic chkn(longint got, longint expv, string req);
    compared++;
    if (got != expv) begin
      mismatched++;
      $display("FAIL %s: got %0d expected %0d", req, got, expv);
    end
  endtask

  task automatic load(int lane, int ip, int fp);
    @(negedge clk);
    cfg_we       = 1'b1;
    cfg_lane     = 2'(lane);
    cfg_wdata    = {ip[15:0], fp[7:0]};
    lane_en      = '0;
    lane_restart = '0;
    lane_restart[lane] = 1'b1;
  endtask

  task automatic run_lane(int lane, int ip, int fp, int ncyc, int off_s, int off_n,
                          bit avg, string req);
    longint e = 0;
    int     hits = 0;
    longint ie = (ip == 0) ? 65536 : ip;
    longint d  = 256 * ie + fp;
    load(lane, ip, fp);
    for (int c = 0; c < ncyc; c++) begin
      bit on;
      @(negedge clk);
      cfg_we       = 1'b0;
      lane_restart = '0;
      on = !(c >= off_s && c < off_s + off_n);
      lane_en = '0;
      lane_en[lane] = on;
      #1;
      chk(lane_tick[lane], on && exp_tick(e, ip, fp), req, lane, e);
      for (int o = 0; o < NL; o++) begin
        if (o != lane) chk(lane_tick[o], 1'b0, "R8", o, e);
      end
      if (lane_tick[lane] && e <= d) hits++;
      if (on) e++;
    end
    if (avg) chkn(hits, 257, "R5 ticks over 256 periods");
    @(negedge clk);
    lane_en = '0;
  endtask

  initial begin
    automatic int fr[5] = '{0, 1, 85, 128, 255};
    automatic int ir[4] = '{1, 2, 3, 7};
    automatic int idx = 0;
    compared = 0;
    mismatched = 0;
    rst_n = 1'b0;
    cfg_we = 1'b0;
    cfg_lane = '0;
    cfg_wdata = '0;
    lane_en = '0;
    lane_restart = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    @(negedge clk); #1;
    for (int l = 0; l < NL; l++) chk(lane_tick[l], 1'b0, "R1 disabled", l, 0);
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      lane_en = '1;
      #1;
      for (int l = 0; l < NL; l++) chk(lane_tick[l], 1'b1, "R1 default 1.0", l, c);
    end
    @(negedge clk);
    lane_en = '0;

    // R3 R5 R6 R2: divisor sweep, rotating lanes
    foreach (ir[i]) begin
      foreach (fr[j]) begin
        run_lane(idx % NL, ir[i], fr[j], 256 * ir[i] + fr[j] + 1, 0, 0, 1'b1,
                 (fr[j] == 0) ? ((ir[i] == 1) ? "R6" : "R3") : "R5");
        idx++;
      end
    end

    // R8: disable window holds phase
    run_lane(1, 5, 0, 40, 7, 20, 1'b0, "R8 hold");
    run_lane(3, 2, 128, 60, 4, 9, 1'b0, "R8 frac hold");

    // R9: mid-period divisor change
    load(0, 4, 0);
    for (int c = 0; c < 25; c++) begin
      @(negedge clk);
      cfg_we = (c == 2);
      cfg_wdata = {16'd7, 8'd0};
      lane_restart = '0;
      lane_en = 4'b0001;
      #1;
      chk(lane_tick[0], (c == 0 || c == 4 || c == 11 || c == 18), "R9", 0, c);
    end
    @(negedge clk);
    cfg_we = 1'b0;
    lane_en = '0;

    // R7 R2: per-lane divisors, joint restart realigns
    for (int l = 0; l < NL; l++) load(l, l + 2, 0);
    @(negedge clk);
    cfg_we = 1'b0;
    lane_restart = '1;
    begin
      longint e = 0;
      for (int c = 0; c < 52; c++) begin
        @(negedge clk);
        lane_restart = (c == 30) ? '1 : '0;
        lane_en = '1;
        #1;
        for (int l = 0; l < NL; l++) chk(lane_tick[l], exp_tick(e, l + 2, 0), "R7", l, e);
        e = (c == 30) ? 0 : e + 1;
      end
    end
    @(negedge clk);
    lane_en = '0;
    lane_restart = '0;

    // R4: integer field zero
    run_lane(2, 0, 0, 65538, 0, 0, 1'b0, "R4");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule